// File: doc/BRIEF.md
# Binary Logarithm Recoder

This block turns one probability word per clock cycle into its base-2 logarithm. The result is a two's complement fixed-point value. The input arrives in one of two encodings, and a mode input picks which one:

- **Float:** a normalized floating-point value 1.s × 2^x, with a biased exponent x and a fractional significand s.
- **Fixed:** an unsigned fixed-point fraction 0.b.

A fixed-point word first goes through a normalizer. The normalizer finds the leading one, moves the bits that follow it into a significand, and sets the exponent to minus the weight position of that one. Both paths then share one stage. A table, filled at elaboration by a constant function, gives log2 of the significand with its implicit leading one. The result's integer field is the exponent as it stands, and its fraction field is the table word. The exponent bias is left in on purpose: a downstream stage subtracts one class term from another, and the bias drops out there.

The result is registered, and a valid strobe travels with it, one cycle behind the input strobe. An all-zero fixed-point word has no logarithm. It is flagged and clamped to the most negative code. The block has two operating modes, `MODE_FLOAT` and `MODE_FIXED`, set per word by `sel_fixed` (0 and 1 respectively). It keeps no state beyond its output register, so any word may switch modes relative to the one before.

Top module: `lg2_recoder`

## Requirements
- R1: While reset is held and on the first edge after it, `out_valid`, `out_zero` and `out_log` are all zero.
- R2: `out_valid` equals the `in_valid` value sampled on the previous rising edge. A new word is accepted on every cycle, including cycles that change mode.
- R3: In float mode (`sel_fixed`=0), `flt_word` is split as bit 16 = sign, bits 15:8 = exponent, bits 7:0 = significand. `out_log[15:8]` equals the exponent unchanged. `out_log[7:0]` is within one LSB of floor(256·log2(1 + s/256)), where s is the significand, and is exactly 0 when s = 0.
- R4: The sign bit `flt_word[16]` has no effect on `out_log` or `out_zero`.
- R5: In fixed mode (`sel_fixed`=1), `fix_word` is a 9-bit value with weight 2^-(9-i) for bit i. The bit ordering of `fix_word` is assumed to be this one. For a nonzero word whose highest set bit has weight 2^-k:
  - `out_log[15:8]` equals -k in 8-bit two's complement.
  - `out_log[7:0]` follows the R3 table rule, where s is the 8-bit value formed by the bits below the leading one, left-aligned and zero-padded.
- R6: A fixed-mode word of zero gives `out_zero`=1 and `out_log`=16'h8000. Every float word and every nonzero fixed word gives `out_zero`=0.
- R7: A fixed word whose only set bit is the top bit (value 0.5) gives exactly 16'hFF00 (-1.0). A word whose only set bit is bit 0 gives exactly 16'hF700 (-9.0).
- R8: In a cycle with `in_valid`=0, `out_log` and `out_zero` keep their previous values, whatever the data and mode inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present this cycle |
| sel_fixed | input | 1 | 0 = float mode, 1 = fixed mode |
| flt_word | input | 17 | Float word {sign, exponent[7:0], significand[7:0]} |
| fix_word | input | 9 | Unsigned fixed-point fraction |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_log | output | 16 | log2 result: signed integer [15:8], fraction [7:0] |
| out_zero | output | 1 | Fixed-point input was zero; result clamped |

## Verification
Two functions can act in the same cycle. The zero-input clamp can coincide with a mode switch, and a hold cycle can follow right after a clamped word. The bench provokes both. It interleaves directed zero fixed words between float words at full rate, then drops `in_valid` while it scrambles the data and mode inputs. It judges each case against a bench model: the clamp code must appear only for the zero word, the float words on either side must be unaffected, and the clamped value must survive the idle cycle unchanged.

// File: rtl/lg2_pkg.sv
package lg2_pkg;
    parameter int EXP_W  = 8;
    parameter int SIG_W  = 8;
    localparam int FIX_W  = SIG_W + 1;
    localparam int OUT_W  = EXP_W + SIG_W;
    localparam int FLT_W  = 1 + EXP_W + SIG_W;
    localparam int CALC_W = 30;

    typedef enum logic {
        MODE_FLOAT = 1'b0,
        MODE_FIXED = 1'b1
    } mode_e;

    localparam logic [OUT_W-1:0] LOG_MIN = {1'b1, {(OUT_W-1){1'b0}}};
endpackage

// File: rtl/lg2_normalizer.sv
module lg2_normalizer
    import lg2_pkg::*;
(
    input  logic [FIX_W-1:0] fix_i,
    output logic [EXP_W-1:0] exp_o,
    output logic [SIG_W-1:0] sig_o,
    output logic             zero_o
);
    logic [FIX_W:0] shifted;
    int             lead_pos;
    int             shift_k;

    always_comb begin
        lead_pos = 0;
        for (int i = 0; i < FIX_W; i++) begin
            if (fix_i[i]) lead_pos = i;
        end
        shift_k = FIX_W - lead_pos;
        shifted = {1'b0, fix_i} << shift_k;
        sig_o   = shifted[FIX_W-1:1];
        exp_o   = EXP_W'(0) - EXP_W'(shift_k);
        zero_o  = (fix_i == '0);
    end
endmodule

// File: rtl/lg2_table.sv
module lg2_table
    import lg2_pkg::*;
#(
    parameter int IDX_W = SIG_W
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] frac_o
);
    localparam int DEPTH = 1 << IDX_W;

    function automatic logic [IDX_W-1:0] lg_frac(input int idx);
        longint acc;
        logic [IDX_W-1:0] res;
        acc = (longint'(1) << CALC_W) + (longint'(idx) << (CALC_W - IDX_W));
        res = '0;
        for (int b = IDX_W - 1; b >= 0; b--) begin
            acc = (acc * acc) >>> CALC_W;
            if (acc >= (longint'(2) << CALC_W)) begin
                res[b] = 1'b1;
                acc    = acc >>> 1;
            end
        end
        return res;
    endfunction

    logic [IDX_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = lg_frac(g);
    end

    assign frac_o = rom[idx_i];
endmodule

// File: rtl/lg2_recoder.sv
module lg2_recoder
    import lg2_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             sel_fixed,
    input  logic [FLT_W-1:0] flt_word,
    input  logic [FIX_W-1:0] fix_word,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_log,
    output logic             out_zero
);
    mode_e            mode;
    logic [EXP_W-1:0] norm_exp;
    logic [SIG_W-1:0] norm_sig;
    logic             norm_zero;
    logic [EXP_W-1:0] exp_sel;
    logic [SIG_W-1:0] sig_sel;
    logic             zero_sel;
    logic [SIG_W-1:0] frac_lk;

    assign mode = mode_e'(sel_fixed);

    lg2_normalizer i_norm (
        .fix_i  (fix_word),
        .exp_o  (norm_exp),
        .sig_o  (norm_sig),
        .zero_o (norm_zero)
    );

    always_comb begin
        unique case (mode)
            MODE_FIXED: begin
                exp_sel  = norm_exp;
                sig_sel  = norm_sig;
                zero_sel = norm_zero;
            end
            MODE_FLOAT: begin
                exp_sel  = flt_word[EXP_W+SIG_W-1:SIG_W];
                sig_sel  = flt_word[SIG_W-1:0];
                zero_sel = 1'b0;
            end
            default: begin
                exp_sel  = '0;
                sig_sel  = '0;
                zero_sel = 1'b0;
            end
        endcase
    end

    lg2_table #(.IDX_W(SIG_W)) i_table (
        .idx_i  (sig_sel),
        .frac_o (frac_lk)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_log   <= '0;
            out_zero  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_zero <= zero_sel;
                out_log  <= zero_sel ? LOG_MIN : {exp_sel, frac_lk};
            end
        end
    end

    AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_log) && $stable(out_zero))); // R8
    AST_ZERO_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        out_zero |-> (out_log == LOG_MIN)); // R6
    AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_fixed && fix_word == '0) |=> out_zero); // R6
    AST_FLOAT_NOZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sel_fixed) |=> !out_zero); // R6
    AST_FLOAT_EXP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sel_fixed) |=> (out_log[OUT_W-1:SIG_W] == $past(flt_word[EXP_W+SIG_W-1:SIG_W]))); // R3
    AST_FIXED_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_fixed && fix_word != '0) |=> out_log[OUT_W-1]); // R5
endmodule

// File: tb/test_lg2_recoder.sv
module test_lg2_recoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        sel_fixed = 1'b0;
    logic [16:0] flt_word = '0;
    logic [8:0]  fix_word = '0;
    logic        out_valid;
    logic [15:0] out_log;
    logic        out_zero;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] exp_log = '0;
    logic        exp_zero = 1'b0;
    logic        exp_valid = 1'b0;
    string       exp_req = "R1";

    always #5 clk = ~clk;

    lg2_recoder i_lg2_recoder (
        .clk, .rst_n, .in_valid, .sel_fixed, .flt_word, .fix_word,
        .out_valid, .out_log, .out_zero
    );

    function automatic int ref_frac(input int s);
        real v;
        v = $ln(1.0 + real'(s) / 256.0) / $ln(2.0) * 256.0;
        return int'($floor(v));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv, input string what);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic check_prev();
        int diff;
        check(exp_req, 32'(out_valid), 32'(exp_valid), "out_valid");
        check(exp_req, 32'(out_zero), 32'(exp_zero), "out_zero");
        check(exp_req, 32'(out_log[15:8]), 32'(exp_log[15:8]), "int field");
        diff = int'(out_log[7:0]) - int'(exp_log[7:0]);
        checks++;
        if (diff > 1 || diff < -1 || (exp_log[7:0] == 8'h00 && out_log[7:0] != 8'h00)) begin
            failures++;
            $display("FAIL %s frac field actual=%0h expected=%0h", exp_req, out_log[7:0], exp_log[7:0]);
        end
    endtask

    task automatic drive(input bit v, input bit fx, input logic [16:0] fw, input logic [8:0] xw, input string req);
        int k;
        int lead;
        logic [17:0] sh;
        check_prev();
        in_valid  = v;
        sel_fixed = fx;
        flt_word  = fw;
        fix_word  = xw;
        exp_valid = v;
        exp_req   = req;
        if (v) begin
            if (!fx) begin
                exp_zero = 1'b0;
                exp_log  = {fw[15:8], 8'(ref_frac(int'(fw[7:0])))};
            end else if (xw == 9'd0) begin
                exp_zero = 1'b1;
                exp_log  = 16'h8000;
            end else begin
                lead = 0;
                for (int i = 0; i < 9; i++) if (xw[i]) lead = i;
                k  = 9 - lead;
                sh = 18'(xw) << (k - 1);
                exp_zero = 1'b0;
                exp_log  = {8'(-k), 8'(ref_frac(int'(sh[7:0])))};
            end
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [16:0] fw;
        logic [8:0]  xw;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: outputs are zero during reset
        check("R1", {out_valid, out_zero, out_log}, 32'd0, "reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {out_valid, out_zero, out_log}, 32'd0, "after first edge");
        exp_req = "R1";

        // R3: zero significand gives exact integer
        drive(1, 0, {1'b0, 8'h7F, 8'h00}, '0, "R3");
        drive(1, 0, {1'b0, 8'h81, 8'hFF}, '0, "R3");
        drive(1, 0, {1'b0, 8'h00, 8'h80}, '0, "R3");
        // R4: sign bit ignored
        drive(1, 0, {1'b1, 8'h7F, 8'h80}, '0, "R4");
        drive(1, 0, {1'b1, 8'h12, 8'h00}, '0, "R4");
        // R7: exact powers of two
        drive(1, 1, '0, 9'h100, "R7");
        drive(1, 1, '0, 9'h001, "R7");
        // R5: fixed with trailing bits
        drive(1, 1, '0, 9'h1FF, "R5");
        drive(1, 1, '0, 9'h003, "R5");
        drive(1, 1, '0, 9'h055, "R5");
        // R6 with mode switches at full rate
        drive(1, 0, {1'b0, 8'h40, 8'h33}, '0, "R2");
        drive(1, 1, '0, 9'h000, "R6");
        drive(1, 0, {1'b0, 8'h41, 8'h00}, '0, "R6");
        drive(1, 1, '0, 9'h000, "R6");
        // R8: idle with scrambled inputs keeps clamp
        drive(0, 0, 17'h1ABCD, 9'h0AA, "R8");
        drive(0, 1, 17'h05555, 9'h000, "R8");
        drive(1, 1, '0, 9'h0C0, "R5");
        drive(0, 0, 17'h0FFFF, 9'h1FF, "R8");
        // random mix
        for (int n = 0; n < 400; n++) begin
            fw = 17'($urandom);
            xw = 9'($urandom);
            if (($urandom % 8) == 0) xw = '0;
            drive(($urandom % 5) != 0, $urandom % 2, fw, xw, "R2");
        end
        drive(0, 0, '0, '0, "R8");
        check_prev();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule